// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block stands in front of an interrupt controller that understands only two kinds of request: a rising edge or an active-high level. A bank of raw wakeup lines arrives asynchronously. Every line has its own configuration word, which selects how that line triggers and whether it is enabled. Two flops synchronize each line. A per-line stage then inverts it or edge-detects it, so the output is always in the form the controller accepts. A falling edge, a rising edge and either transition of a dual-edge line each become a single-cycle high pulse. A level line becomes an active-high level, inverted first if the line is active-low.

Software reaches the configuration words and a constant identification register over a simple register port. Writes complete in one cycle and take a per-bit write mask. Reads are combinational from the address. A write that changes the trigger type of a line forces that line's output low for the next cycle. Any edge that lands in that cycle is discarded, so a type change never leaves a spurious event behind.

Top module: `wkp_polarity_norm`

## Requirements
- R1: Trigger code 3'b100 (level, active-high) drives the output high while the synchronized input is high and low while it is low.
- R2: Trigger code 3'b000 (level, active-low) drives the output high while the synchronized input is low and low while it is high.
- R3: Trigger code 3'b110 (rising) gives a one-cycle output pulse for each low-to-high input transition and no pulse for a high-to-low transition.
- R4: Trigger code 3'b010 (falling) gives a one-cycle output pulse for each high-to-low input transition and no pulse for a low-to-high transition.
- R5: Trigger code 3'b111 (dual) gives one one-cycle output pulse for every input transition in either direction.
- R6: Bit 3 of a configuration word is the enable. A line whose enable is 0, or whose trigger code is any value not listed in R1 to R5, holds its output low.
- R7: Line i's configuration word is at byte address 0x110 + 4*i. Bits [2:0] hold the trigger code, bit 3 holds the enable, and all other bits read as 0. A write changes only the bits whose write-mask bit is 1.
- R8: A read of byte address 0x1000 returns 32'h0003_0200. A read of an address that maps to no register returns 0.
- R9: A write that changes a line's trigger code forces that line's output low in the following cycle, which discards any edge detected in that cycle. A write that leaves the code unchanged has no effect on the output.
- R10: After reset every configuration word reads 0 (code 000, disabled) and every output is low.
- R11: An input change first appears at the output after the third rising clock edge that follows it (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Raw asynchronous wakeup lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write mask, 1 = bit is written |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | NUM_PINS | Normalized rising-edge / active-high requests |

## Verification
A synchronized edge and a register write can reach the same line in the same cycle. When that write changes the trigger type, the clear wins and the edge must be lost. The bench provokes this by changing a pin so that its edge reaches the output register on exactly the clock edge that also takes a type-changing write. Counting zero output pulses in the following cycles confirms the edge was dropped. The same alignment with a write that leaves the code unchanged must still produce exactly one pulse, which shows the clear is tied to the change and not to every write.

// File: rtl/wkp_pkg.sv
// Shared constants for the wakeup polarity normalizer.
// Assumes byte addressing with 32-bit registers.
package wkp_pkg;
    localparam logic [2:0] TRIG_LVL_LO = 3'b000;
    localparam logic [2:0] TRIG_FALL   = 3'b010;
    localparam logic [2:0] TRIG_LVL_HI = 3'b100;
    localparam logic [2:0] TRIG_RISE   = 3'b110;
    localparam logic [2:0] TRIG_BOTH   = 3'b111;

    localparam int          CFG_BASE   = 32'h110;
    localparam int          VER_ADDR   = 32'h1000;
    localparam logic [31:0] VERSION_ID = 32'h0003_0200;
    localparam int          MAX_PINS   = 256;
endpackage

// File: rtl/wkp_sync.sv
// Two-flop synchronizer for a vector of asynchronous lines.
// Assumes each bit is an independent signal (no bus coherency needed).
module wkp_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Two-stage capture of the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/wkp_cfg_regs.sv
// Per-line configuration words and the identification register.
// Assumes one-cycle writes with a bit mask and combinational reads;
// only bits [3:0] of each configuration word are stored.
module wkp_cfg_regs
    import wkp_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wdata,
    input  logic [31:0]               wmask,
    output logic [31:0]               rdata,
    output logic [NUM_PINS-1:0][2:0]  trig_type,
    output logic [NUM_PINS-1:0]       trig_en,
    output logic [NUM_PINS-1:0]       type_chg
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] VER_A  = ADDR_W'(VER_ADDR);

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic              unused_bits;

    assign unused_bits = ^{wdata[31:4], wmask[31:4]};

    // Decode the address into a line index and a hit flag.
    always_comb begin
        off = addr - BASE_A;
        hit = (addr >= BASE_A) && (off[1:0] == 2'b00)
              && ((off >> 2) < ADDR_W'(NUM_PINS));
        idx = off[IDX_W+1:2];
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_word
        logic       sel;
        logic [2:0] nxt_type;
        logic       nxt_en;

        // Merge write data under the mask for this line.
        always_comb begin
            sel      = wr_en && hit && (idx == IDX_W'(g));
            nxt_type = (trig_type[g] & ~wmask[2:0]) | (wdata[2:0] & wmask[2:0]);
            nxt_en   = wmask[3] ? wdata[3] : trig_en[g];
            type_chg[g] = sel && (nxt_type != trig_type[g]);
        end

        // Store the line's trigger code and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trig_type[g] <= TRIG_LVL_LO;
                trig_en[g]   <= 1'b0;
            end else if (sel) begin
                trig_type[g] <= nxt_type;
                trig_en[g]   <= nxt_en;
            end
        end
    end

    // Read multiplexer over the identification and configuration words.
    always_comb begin
        rdata = '0;
        if (addr == VER_A) begin
            rdata = VERSION_ID;
        end else if (hit) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (idx == IDX_W'(i)) begin
                    rdata = {28'd0, trig_en[i], trig_type[i]};
                end
            end
        end
    end
endmodule

// File: rtl/wkp_lane.sv
// Polarity and edge conversion for one synchronized line.
// Assumes sync_in is already in the clk domain; the output is registered.
module wkp_lane
    import wkp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic [2:0] trig_type,
    input  logic       trig_en,
    input  logic       type_chg,
    output logic       req_out
);
    logic prev_q;
    logic req_nxt;

    // Select the normalized request for the configured trigger code.
    always_comb begin
        case (trig_type)
            TRIG_LVL_LO: req_nxt = ~sync_in;
            TRIG_LVL_HI: req_nxt = sync_in;
            TRIG_RISE:   req_nxt = sync_in & ~prev_q;
            TRIG_FALL:   req_nxt = ~sync_in & prev_q;
            TRIG_BOTH:   req_nxt = sync_in ^ prev_q;
            default:     req_nxt = 1'b0;
        endcase
        if (!trig_en || type_chg) begin
            req_nxt = 1'b0;
        end
    end

    // Hold the previous sample and register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            req_out <= 1'b0;
        end else begin
            prev_q  <= sync_in;
            req_out <= req_nxt;
        end
    end
endmodule

// File: rtl/wkp_polarity_norm.sv
// Top of the wakeup polarity normalizer: synchronizer, register bank
// and one conversion lane per line. Assumes NUM_PINS <= 256.
module wkp_polarity_norm
    import wkp_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [31:0]         bus_wmask,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_out
);
    logic [NUM_PINS-1:0]      pin_sync;
    logic [NUM_PINS-1:0][2:0] cfg_type;
    logic [NUM_PINS-1:0]      cfg_en;
    logic [NUM_PINS-1:0]      type_chg;

    if (NUM_PINS > MAX_PINS || NUM_PINS < 1 || ADDR_W < 13) begin : g_bad_param
        initial $error("wkp_polarity_norm: unsupported parameters");
    end

    wkp_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    wkp_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wmask     (bus_wmask),
        .rdata     (bus_rdata),
        .trig_type (cfg_type),
        .trig_en   (cfg_en),
        .type_chg  (type_chg)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
        wkp_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (pin_sync[g]),
            .trig_type (cfg_type[g]),
            .trig_en   (cfg_en[g]),
            .type_chg  (type_chg[g]),
            .req_out   (irq_out[g])
        );
    end
endmodule

// File: rtl/wkp_polarity_norm_chk.sv
// Property checker for wkp_polarity_norm, attached by bind.
// Assumes it observes the register bank outputs of the top.
module wkp_polarity_norm_chk
    import wkp_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_rdata,
    input logic [NUM_PINS-1:0]       irq_out,
    input logic [NUM_PINS-1:0][2:0]  cfg_type,
    input logic [NUM_PINS-1:0]       cfg_en,
    input logic [NUM_PINS-1:0]       type_chg
);
    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(VER_ADDR)) |-> (bus_rdata == VERSION_ID)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0)); // R10

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic one_shot;
        assign one_shot = (cfg_type[g] == TRIG_RISE) || (cfg_type[g] == TRIG_FALL);

        AST_TYPE_CHANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            type_chg[g] |=> !irq_out[g]); // R9

        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[g] |=> !irq_out[g]); // R6

        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[g] && one_shot) |=> (!irq_out[g] || !one_shot)); // R3
    end
endmodule

bind wkp_polarity_norm wkp_polarity_norm_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .cfg_type  (cfg_type),
    .cfg_en    (cfg_en),
    .type_chg  (type_chg)
);

// File: tb/wkp_polarity_norm_bench.sv
`timescale 1ns/1ps
module wkp_polarity_norm_bench;
    localparam int NUM_PINS = 16;
    localparam int ADDR_W   = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_PINS-1:0] pin_in = '0;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_wmask = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_PINS-1:0] irq_out;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    wkp_polarity_norm #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_wkp_polarity_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wmask (bus_wmask),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Vector fields: {code[2:0], en, start, final_in, pre_out, highs[3:0], final_out}
    localparam int NVEC = 13;
    localparam logic [11:0] VEC [NVEC] = '{
        {3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0},
        {3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        {3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0},
        {3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        {3'b111, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0},
        {3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0},
        {3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6, 1'b1},
        {3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0},
        {3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 1'b1},
        {3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 1'b0},
        {3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        {3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        {3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0}
    };

    function automatic string req_of(input logic [2:0] code, input logic en);
        if (!en) return "R6";
        case (code)
            3'b100:  return "R1";
            3'b000:  return "R2";
            3'b110:  return "R3";
            3'b010:  return "R4";
            3'b111:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input logic [31:0] data, input logic [31:0] mask);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        bus_wmask = mask;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic reg_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int highs;
        logic last;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state of outputs and configuration words.
        check("R10", "irq_out after reset", 32'(irq_out), 32'h0);
        reg_read(32'h110, rd);
        check("R10", "cfg line 0 after reset", rd, 32'h0);
        reg_read(32'h110 + 4 * (NUM_PINS - 1), rd);
        check("R10", "cfg last line after reset", rd, 32'h0);

        // R8: identification register and unmapped address.
        reg_read(32'h1000, rd);
        check("R8", "version read", rd, 32'h0003_0200);
        reg_read(32'h104, rd);
        check("R8", "unmapped read", rd, 32'h0);

        // Table walk on line 0 for every trigger mode.
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] code;
            logic       en, st, fn, pre, fo;
            logic [3:0] hi;
            string      r;
            {code, en, st, fn, pre, hi, fo} = VEC[v];
            r = req_of(code, en);
            reg_write(32'h110, {28'd0, en, code}, 32'hF);
            @(negedge clk);
            pin_in[0] = st;
            idle(7);
            check(r, $sformatf("vec %0d output before change", v), 32'(irq_out[0]), 32'(pre));
            pin_in[0] = fn;
            highs = 0;
            last  = 1'b0;
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                if (irq_out[0]) highs++;
                last = irq_out[0];
            end
            check(r, $sformatf("vec %0d high cycles (R11 latency)", v), 32'(highs), 32'(hi));
            check(r, $sformatf("vec %0d final output", v), 32'(last), 32'(fo));
        end

        // R7: masked writes keep unmasked bits; high bits read zero.
        reg_write(32'h110, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        reg_read(32'h110, rd);
        check("R7", "unused bits read zero", rd, 32'hF);
        reg_write(32'h110, 32'h0000_000C, 32'hF);
        reg_write(32'h110, 32'h0000_0006, 32'h7);
        reg_read(32'h110, rd);
        check("R7", "type write keeps enable", rd, 32'hE);
        reg_write(32'h110, 32'h0000_0000, 32'h8);
        reg_read(32'h110, rd);
        check("R7", "enable write keeps type", rd, 32'h6);

        // R7: stride addressing reaches line 3 only.
        reg_write(32'h11C, 32'h0000_000C, 32'hF);
        reg_read(32'h11C, rd);
        check("R7", "line 3 word", rd, 32'hC);
        reg_read(32'h118, rd);
        check("R7", "line 2 untouched", rd, 32'h0);
        pin_in[3] = 1'b1;
        idle(4);
        check("R7", "line 3 level output", 32'(irq_out[3]), 32'h1);
        pin_in[3] = 1'b0;

        // R9: edge coincides with a type-changing write -> dropped.
        reg_write(32'h110, 32'h0000_000E, 32'hF);
        pin_in[0] = 1'b0;
        idle(6);
        pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(32'h110);
        bus_wdata = 32'h7; bus_wmask = 32'h7;
        @(negedge clk);
        bus_wr = 1'b0;
        highs = 0;
        for (int s = 0; s < 6; s++) begin
            if (irq_out[0]) highs++;
            @(negedge clk);
        end
        check("R9", "edge dropped on type change", 32'(highs), 32'h0);
        reg_read(32'h110, rd);
        check("R9", "code now dual", rd, 32'hF);

        // R9: same alignment, write leaves code unchanged -> pulse kept.
        pin_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(32'h110);
        bus_wdata = 32'h7; bus_wmask = 32'h7;
        @(negedge clk);
        bus_wr = 1'b0;
        highs = 0;
        for (int s = 0; s < 6; s++) begin
            if (irq_out[0]) highs++;
            @(negedge clk);
        end
        check("R9", "same-code write keeps pulse", 32'(highs), 32'h1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule